// File: doc/BRIEF.md
# Ping-Pong Receive Packet Buffer

This block buffers received packets for one USB OUT endpoint. The USB side delivers a packet as a burst of bytes followed by an end strobe that marks the packet good or bad. The CPU or DMA side reads those bytes through a byte-wide read port. Storage is split into two banks, each one maximum packet long. One bank can fill while the other is being drained.

A packet is written into the bank that is free. A good end hands the bank to the reader: the full flag rises and the packet's byte count appears on the size output. The reader pulls the bytes one at a time with a read strobe. This strobe serves both as a CPU read and as a DMA acknowledge, and a DMA request stays high while unread bytes remain. The reader then pulses the read-finished trigger to give the bank back. When both banks hold packets, the receive side is told to refuse further packets with NAK. A clear input empties both banks at any time.

Top module: `pingpong_rx_buf`

## Requirements
- R1: After reset, `full_flag`, `dma_req` and `rx_nak` are 0 and `rx_size` reads 0.
- R2: A good end (`rx_end_ok`) raises `full_flag`, and `rx_size` then shows the number of bytes received in that packet (1 to BANK_BYTES).
- R3: Each `rd_en` pulse advances the read pointer. `rd_data` presents the packet bytes in the order in which they were received, starting at the first byte.
- R4: A `rd_done` pulse releases the bank being read. `full_flag` stays 1 if the other bank still holds a packet, and falls to 0 otherwise.
- R5: When two packets are buffered, the older one is presented first. After it is released, `rx_size` and `rd_data` switch to the newer one.
- R6: While both banks are full, `rx_nak` is 1, incoming bytes are not stored, and a good end has no effect on the buffered packets.
- R7: A bad end (`rx_end_bad`) discards the packet. `full_flag` and `rx_size` keep their values, and the next packet starts at the beginning of the same bank.
- R8: `dma_req` is 1 while the presented bank has unread bytes. It falls in the cycle after the last byte is read.
- R9: A packet longer than BANK_BYTES is discarded even if it ends with a good end.
- R10: `flush` empties both banks and resets all pointers. The next packet is read back from its first byte.
- R11: A zero-length good packet raises `full_flag` with `rx_size` equal to 0 and `dma_req` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of both banks |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_end_ok | input | 1 | Packet ended without error |
| rx_end_bad | input | 1 | Packet ended with error or abort |
| rx_nak | output | 1 | No free bank, answer NAK |
| rd_en | input | 1 | CPU read strobe or DMA acknowledge |
| rd_data | output | 8 | Byte at the read pointer |
| rd_done | input | 1 | Read-finished trigger, releases the bank |
| full_flag | output | 1 | At least one bank holds a packet |
| rx_size | output | $clog2(BANK_BYTES+1) | Byte count of the presented packet |
| dma_req | output | 1 | Unread bytes remain in the presented bank |

## Verification
The bench sweeps every packet length from 0 to 64 and reads each packet back. A wrong count or a pointer off by one shows up as a wrong size or a shifted byte. Two buffered packets are read in order to expose a reader that picks the newest bank. A design that releases the wrong bank, or drops `full_flag` too early, fails this step. A third packet is sent while both banks are full, and bad endings, 65-byte packets and a mid-stream clear are each followed by a clean packet. A design that stored refused data or kept half-written data would corrupt that clean packet or change the reported size.

// File: rtl/pingpong_rx_buf.sv
module pingpong_rx_buf #(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_end_ok,
  input  logic          rx_end_bad,
  output logic          rx_nak,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          rd_done,
  output logic          full_flag,
  output logic [CW-1:0] rx_size,
  output logic          dma_req
);
  localparam logic [CW-1:0] CAP = CW'(BANK_BYTES);

  logic [7:0]    mem [2*BANK_BYTES];
  logic [1:0]    full;
  logic [CW-1:0] cnt [2];
  logic          wb, rb, drop;
  logic [CW-1:0] wp, rp;

  wire wr_ok   = rx_valid && !drop && !full[wb] && (wp != CAP);
  wire pkt_end = rx_end_ok || rx_end_bad;
  wire commit  = rx_end_ok && !drop && !full[wb];
  wire release_bank = rd_done && full[rb];
  wire rd_step = rd_en && full[rb] && (rp != cnt[rb]);

  assign rx_nak    = full[wb];
  assign full_flag = |full;
  assign rx_size   = full[rb] ? cnt[rb] : '0;
  assign dma_req   = full[rb] && (rp != cnt[rb]);
  assign rd_data   = mem[{rb, rp[AW-1:0]}];

  always_ff @(posedge clk)
    if (wr_ok) mem[{wb, wp[AW-1:0]}] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0; wb <= 1'b0; rb <= 1'b0; drop <= 1'b0;
      wp <= '0; rp <= '0; cnt[0] <= '0; cnt[1] <= '0;
    end else if (flush) begin
      full <= '0; wb <= 1'b0; rb <= 1'b0; drop <= 1'b0;
      wp <= '0; rp <= '0; cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      if (pkt_end) begin
        wp   <= '0;
        drop <= 1'b0;
        if (commit) begin
          full[wb] <= 1'b1;
          cnt[wb]  <= wp;
          wb       <= ~wb;
        end
      end else if (wr_ok) begin
        wp <= wp + 1'b1;
      end else if (rx_valid) begin
        drop <= 1'b1;
      end
      if (release_bank) begin
        full[rb] <= 1'b0;
        rb       <= ~rb;
        rp       <= '0;
      end else if (rd_step) begin
        rp <= rp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_rx_checks.sv
module pp_rx_checks #(
  parameter int BANK_BYTES = 64,
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          rx_end_ok,
  input logic          rx_end_bad,
  input logic          rd_done,
  input logic          rx_nak,
  input logic          full_flag,
  input logic          dma_req,
  input logic [CW-1:0] rx_size
);
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!full_flag && !dma_req && !rx_nak));
  a_r2_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_size <= CW'(BANK_BYTES));
  a_r8_req_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> full_flag);
  a_r6_nak_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_nak && !rd_done && !flush) |=> rx_nak);
  a_r11_empty_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && rx_size == '0) |-> !dma_req);
  a_r7_bad_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end_bad && !rx_end_ok && !rd_done && !flush) |=>
      ($stable(full_flag) && $stable(rx_size)));
endmodule

bind pingpong_rx_buf pp_rx_checks #(.BANK_BYTES(BANK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rx_end_ok(rx_end_ok),
  .rx_end_bad(rx_end_bad), .rd_done(rd_done), .rx_nak(rx_nak),
  .full_flag(full_flag), .dma_req(dma_req), .rx_size(rx_size)
);

// File: tb/sim_pingpong_rx_buf.sv
module sim_pingpong_rx_buf;
  localparam int BB = 64;
  localparam int CW = $clog2(BB + 1);

  logic clk = 0, rst_n = 0, flush = 0, rx_valid = 0, rx_end_ok = 0, rx_end_bad = 0;
  logic rd_en = 0, rd_done = 0;
  logic [7:0] rx_data = 0;
  logic rx_nak, full_flag, dma_req;
  logic [7:0] rd_data;
  logic [CW-1:0] rx_size;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  pingpong_rx_buf #(.BANK_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_end_ok(rx_end_ok), .rx_end_bad(rx_end_bad), .rx_nak(rx_nak), .rd_en(rd_en),
    .rd_data(rd_data), .rd_done(rd_done), .full_flag(full_flag), .rx_size(rx_size),
    .dma_req(dma_req));

  function automatic int pat(int seed, int i);
    return (seed * 37 + i * 7 + 3) & 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int n, int seed, bit good);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(pat(seed, i));
    end
    @(negedge clk); rx_valid = 0;
    if (good) rx_end_ok = 1; else rx_end_bad = 1;
    @(negedge clk); rx_end_ok = 0; rx_end_bad = 0;
  endtask

  task automatic drain(int n, int seed, string req);
    for (int i = 0; i < n; i++) begin
      chk("R8 req while unread", int'(dma_req), 1);
      chk(req, int'(rd_data), pat(seed, i));
      rd_en = 1;
      @(negedge clk);
    end
    rd_en = 0;
    chk("R8 req drops after last", int'(dma_req), 0);
    rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 full", int'(full_flag), 0);
    chk("R1 req", int'(dma_req), 0);
    chk("R1 nak", int'(rx_nak), 0);
    chk("R1 size", int'(rx_size), 0);

    for (int len = 0; len <= BB; len++) begin
      send(len, len, 1);
      chk("R2 full", int'(full_flag), 1);
      chk("R2 size", int'(rx_size), len);
      if (len == 0) chk("R11 zero-length req", int'(dma_req), 0);
      drain(len, len, "R3 data");
      chk("R4 full after release", int'(full_flag), 0);
    end

    send(10, 101, 1);
    chk("R6 nak one free", int'(rx_nak), 0);
    send(20, 102, 1);
    chk("R6 nak both full", int'(rx_nak), 1);
    chk("R5 oldest size", int'(rx_size), 10);
    send(5, 103, 1);
    chk("R6 size unchanged", int'(rx_size), 10);
    drain(10, 101, "R5 oldest data");
    chk("R4 full stays", int'(full_flag), 1);
    chk("R5 newer size", int'(rx_size), 20);
    chk("R6 nak cleared", int'(rx_nak), 0);
    drain(20, 102, "R6 refused bytes not stored");
    chk("R6 no third packet", int'(full_flag), 0);

    send(12, 104, 0);
    chk("R7 full unchanged", int'(full_flag), 0);
    send(12, 105, 1);
    chk("R7 size", int'(rx_size), 12);
    send(30, 106, 0);
    chk("R7 size kept", int'(rx_size), 12);
    chk("R7 full kept", int'(full_flag), 1);
    send(7, 107, 1);
    drain(12, 105, "R7 first");
    chk("R7 second size", int'(rx_size), 7);
    drain(7, 107, "R7 bank reused from start");

    send(BB + 1, 108, 1);
    chk("R9 overlong discarded", int'(full_flag), 0);
    send(3, 109, 1);
    chk("R9 next size", int'(rx_size), 3);
    drain(3, 109, "R9 next data");

    send(9, 110, 1);
    send(4, 111, 1);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk("R10 full", int'(full_flag), 0);
    chk("R10 nak", int'(rx_nak), 0);
    chk("R10 req", int'(dma_req), 0);
    chk("R10 size", int'(rx_size), 0);
    send(6, 112, 1);
    chk("R10 size after", int'(rx_size), 6);
    drain(6, 112, "R10 data after clear");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule